// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from one or more identical 4-bit stages. Each stage can be preset from a data word, can advance by one, or can hold its value. Two count enables gate the advance: a parallel enable shared by every stage, and a trickle enable that also qualifies the terminal-count flag. The flag depends only on the current count and the trickle enable, with no register in its path. A stage can therefore feed its flag straight into the trickle enable of the stage above it. All stages then advance on the same clock edge, with no ripple of state between them.

A build-time parameter selects the clear style. In the synchronous style the clear is sampled on the rising edge, and the user can shorten the count period by decoding a count value and driving the clear low. In the asynchronous style the clear forces the count to zero at once. The top module chains `STAGES` stages. All stages share the clock, the clear, the load and the parallel enable. The trickle enable input drives only the lowest stage.

There are no data streams at this block's edge, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status level.

Top module: `cascade_counter`

## Requirements
- R1: With the synchronous clear style (`SYNC_CLEAR=1`), `clr_n` low at a rising edge makes every count bit zero after that edge. This takes priority over `load_n`, `en_par` and `en_trk`.
- R2: With the asynchronous clear style (`SYNC_CLEAR=0`), `clr_n` low forces `count` to zero without a clock edge. The count stays zero across edges while `clr_n` is low, whatever the load and enables are.
- R3: With the clear inactive, `load_n` low at a rising edge copies `din` into `count`, whatever the levels of both enables.
- R4: With the clear inactive, `load_n` high, and `en_par` and `en_trk` both high, stage 0 advances by one at each rising edge.
- R5: With the clear inactive and `load_n` high, if `en_par` or `en_trk` is low, the count keeps its value across the edge.
- R6: Each stage counts 0 through 15 and then wraps to 0.
- R7: `stage_tc[0]` is 1 exactly when `en_trk` is 1 and stage 0 holds 15. `en_par` has no effect on it, and it follows its inputs with no clock edge.
- R8: The trickle enable of stage k (k ≥ 1) is `stage_tc[k-1]`. So `stage_tc[k]` = `stage_tc[k-1]` AND (stage k = 15). On a counting edge, stage k advances on the same edge in which all lower stages wrap, and holds otherwise. Stage k sits at `count[4k+3:4k]`.
- R9: With the synchronous style, driving `clr_n` from a decode of stage 0 equal to N−1 gives a repeating count of 0 through N−1. For N = 7 the sequence is 0,1,…,6,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for every stage |
| clr_n | input | 1 | Active-low clear, synchronous or asynchronous per `SYNC_CLEAR` |
| load_n | input | 1 | Active-low parallel preset from `din` |
| en_par | input | 1 | Parallel count enable, shared by all stages |
| en_trk | input | 1 | Trickle count enable into stage 0; also gates its terminal count |
| din | input | STAGES*WIDTH | Preset data, stage k in bits 4k+3:4k |
| count | output | STAGES*WIDTH | Current count, stage k in bits 4k+3:4k |
| stage_tc | output | STAGES | Terminal-count flag of each stage |

## Verification
The assertions check the priority order on every cycle. After each edge a clear gives zero, a load gives the sampled data, a counting edge gives plus one, and any other edge leaves the count unchanged. They also check that an upper stage never moves on a plain counting edge unless the stage below flags terminal count. Several behaviours can only be shown by the bench's scenarios. These are: the flag ignoring the parallel enable, a zero appearing between clock edges in the asynchronous style, the carry from stage 0 into stage 1, and the shortened modulo-7 period. The bench compares both clear styles against a reference model on every cycle, across tabled and random control patterns.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } cnt_op_t;
endpackage

// File: rtl/cnt_op_select.sv
module cnt_op_select
  import cascade_pkg::*;
#(
  parameter bit SYNC_CLEAR = 1'b1
) (
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_par,
  input  logic    en_trk,
  output cnt_op_t op
);
  logic clear_req;

  // Only the synchronous style turns the clear into an edge operation.
  assign clear_req = SYNC_CLEAR ? ~clr_n : 1'b0;

  always_comb begin
    if (clear_req)             op = OP_CLEAR;
    else if (!load_n)          op = OP_LOAD;
    else if (en_par && en_trk) op = OP_COUNT;
    else                       op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_tc_detect.sv
module cnt_tc_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_trk,
  output logic             tc
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  assign tc = en_trk && (q == TOP);
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cascade_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit SYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_trk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ZERO = '0;

  cnt_op_t op;

  cnt_op_select #(.SYNC_CLEAR(SYNC_CLEAR)) u_sel (
    .clr_n (clr_n),
    .load_n(load_n),
    .en_par(en_par),
    .en_trk(en_trk),
    .op    (op)
  );

  cnt_tc_detect #(.WIDTH(WIDTH)) u_tc (
    .q     (q),
    .en_trk(en_trk),
    .tc    (tc)
  );

  generate
    if (SYNC_CLEAR) begin : g_sync
      always_ff @(posedge clk) begin
        unique case (op)
          OP_CLEAR: q <= ZERO;
          OP_LOAD:  q <= din;
          OP_COUNT: q <= q + ONE;
          default:  q <= q;
        endcase
      end

      // R1
      sync_clear_chk: assert property (@(posedge clk)
        !clr_n |=> (q == ZERO));
    end else begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
          q <= ZERO;
        end else begin
          unique case (op)
            OP_LOAD:  q <= din;
            OP_COUNT: q <= q + ONE;
            default:  q <= q;
          endcase
        end
      end

      // R2
      async_clear_chk: assert property (@(posedge clk)
        !clr_n |-> (q == ZERO));
    end
  endgenerate

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> (q == $past(din)));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk) |=> (q == $past(q) + ONE));

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_par && en_trk)) |=> $stable(q));

  // R7
  tc_full_chk: assert property (@(posedge clk) disable iff (!clr_n)
    tc |-> (&q));
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int STAGES     = 2,
  parameter int WIDTH      = 4,
  parameter bit SYNC_CLEAR = 1'b1
) (
  input  logic                    clk,
  input  logic                    clr_n,
  input  logic                    load_n,
  input  logic                    en_par,
  input  logic                    en_trk,
  input  logic [STAGES*WIDTH-1:0] din,
  output logic [STAGES*WIDTH-1:0] count,
  output logic [STAGES-1:0]       stage_tc
);
  localparam int TOTAL = STAGES * WIDTH;

  logic [STAGES-1:0] trk_in;

  assign trk_in[0] = en_trk;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k > 0) begin : g_link
        assign trk_in[k] = stage_tc[k-1];

        // R8
        upper_stall_chk: assert property (@(posedge clk) disable iff (!clr_n)
          (load_n && !stage_tc[k-1]) |=> $stable(count[k*WIDTH +: WIDTH]));
      end

      cnt_stage #(.WIDTH(WIDTH), .SYNC_CLEAR(SYNC_CLEAR)) u_cnt (
        .clk   (clk),
        .clr_n (clr_n),
        .load_n(load_n),
        .en_par(en_par),
        .en_trk(trk_in[k]),
        .din   (din[k*WIDTH +: WIDTH]),
        .q     (count[k*WIDTH +: WIDTH]),
        .tc    (stage_tc[k])
      );
    end
  endgenerate

  // R8
  tc_chain_chk: assert property (@(posedge clk) disable iff (!clr_n)
    stage_tc[STAGES-1] |-> (&count[TOTAL-1:0]));
endmodule

// File: tb/test_cascade_counter.sv
module test_cascade_counter;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       a_clr_n = 1'b0;
  logic       load_n = 1'b1;
  logic       en_par = 1'b0;
  logic       en_trk = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] count, a_count;
  logic [1:0] stage_tc, a_stage_tc;

  int checks = 0;
  int errors = 0;
  logic [7:0] sm, am;

  always #10 clk = ~clk;

  cascade_counter #(.STAGES(2), .WIDTH(4), .SYNC_CLEAR(1'b1)) i_cascade_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par), .en_trk(en_trk),
    .din(din), .count(count), .stage_tc(stage_tc)
  );

  cascade_counter #(.STAGES(2), .WIDTH(4), .SYNC_CLEAR(1'b0)) i_cascade_counter_async (
    .clk(clk), .clr_n(a_clr_n), .load_n(load_n), .en_par(en_par), .en_trk(en_trk),
    .din(din), .count(a_count), .stage_tc(a_stage_tc)
  );

  // {clr_n, load_n, en_par, en_trk, din}
  localparam logic [11:0] VEC [16] = '{
    {4'b1000, 8'h0D}, {4'b1111, 8'h00}, {4'b1111, 8'h00}, {4'b1111, 8'h00},
    {4'b1101, 8'h00}, {4'b1110, 8'h00}, {4'b1011, 8'hFE}, {4'b1111, 8'h00},
    {4'b1101, 8'h00}, {4'b1111, 8'h00}, {4'b0011, 8'h55}, {4'b1011, 8'h3C},
    {4'b0111, 8'h00}, {4'b1000, 8'h0F}, {4'b1110, 8'h00}, {4'b1111, 8'h00}
  };

  function automatic logic [7:0] next_val(logic [7:0] cur, logic c, logic l,
                                          logic ep, logic et, logic [7:0] d);
    logic [7:0] n;
    n = cur;
    if (!c) n = 8'h00;
    else if (!l) n = d;
    else if (ep && et) begin
      n[3:0] = cur[3:0] + 4'd1;
      if (cur[3:0] == 4'hF) n[7:4] = cur[7:4] + 4'd1;
    end
    return n;
  endfunction

  function automatic logic [1:0] tc_of(logic [7:0] cur, logic et);
    logic t0;
    t0 = et && (cur[3:0] == 4'hF);
    return {t0 && (cur[7:4] == 4'hF), t0};
  endfunction

  function automatic string tag_of(logic [7:0] cur, logic c, logic l, logic ep, logic et);
    if (!c) return "R1";
    if (!l) return "R3";
    if (ep && et) begin
      if (cur[3:0] == 4'hF) return (cur[7:4] == 4'hF) ? "R6" : "R8";
      return "R4";
    end
    return "R5";
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(logic c, logic ac, logic l, logic ep, logic et, logic [7:0] d,
                      string force_tag);
    string ts, ta;
    clr_n = c; a_clr_n = ac; load_n = l; en_par = ep; en_trk = et; din = d;
    if (!ac) am = 8'h00;
    #1;
    check(ep ? "R7" : "R7 en_par low", {6'd0, stage_tc}, {6'd0, tc_of(sm, et)});
    check("R7 async", {6'd0, a_stage_tc}, {6'd0, tc_of(am, et)});
    ts = (force_tag != "") ? force_tag : tag_of(sm, c, l, ep, et);
    ta = !ac ? "R2" : tag_of(am, 1'b1, l, ep, et);
    sm = next_val(sm, c, l, ep, et, d);
    am = next_val(am, ac, l, ep, et, d);
    @(posedge clk);
    @(negedge clk);
    check(ts, count, sm);
    check(ta, a_count, am);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    sm = 8'h00; am = 8'h00;
    @(negedge clk);
    @(negedge clk);
    // reset state: R1 sync clear, R2 async clear
    check("R1 reset", count, 8'h00);
    check("R2 reset", a_count, 8'h00);
    check("R7 reset", {6'd0, stage_tc}, 8'h00);
    a_clr_n = 1'b1; clr_n = 1'b1;

    for (int i = 0; i < 16; i++)
      step(VEC[i][11], 1'b1, VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0], "");

    // R2: asynchronous clear between edges
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h9A, "R3");
    load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1;
    #5 a_clr_n = 1'b0;
    #1 check("R2 no edge", a_count, 8'h00);
    load_n = 1'b0; din = 8'h77;
    @(posedge clk);
    @(negedge clk);
    check("R2 held over load", a_count, 8'h00);
    am = 8'h00; sm = next_val(sm, 1'b1, 1'b0, 1'b1, 1'b1, 8'h77);
    check("R3", count, sm);

    // R8: carry across stages and trickle chain flags
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hEE, "R3");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R8");

    // R9: modulo-7 using stage-0 decode of 6 on the synchronous clear
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R9");
    for (int i = 0; i < 21; i++) begin
      step((count[3:0] != 4'd6), 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R9");
      if (count[3:0] > 4'd6) check("R9 range", count, 8'h06);
    end

    // random priority sweep over all control inputs
    for (int i = 0; i < 400; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step(r[7:3] != 5'd0, r[6:2] != 5'd0, r[1:0] != 2'b00, r[2], r[3] | r[4], 8'($urandom), "");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule